// File: doc/BRIEF.md
# Pointer-Based Stuck-Cell Line Repair

This block keeps a line of memory usable after some of its cells have failed permanently. A Hamming code would spread each data change over many check bits. This block instead keeps a short table of correction entries. Each entry records the bit position of a failed cell, a substitute cell holding that position's true value, and a valid bit. Entries are taken one at a time, starting from the lowest index, each time a write-verify step reports a newly stuck cell. A full flag shows that no free entry remains.

Requests arrive on a valid/ready handshake. A read request carries the raw line as it came from the array. The block returns the line with every covered position replaced by its substitute bit. A write request carries the data being stored. Each valid entry copies the data bit at its own position into its substitute cell. An allocate request names the failed position and the value that position should hold. When the same position is allocated more than once, the higher-index entry decides that bit. A damaged entry can therefore be repaired by allocating a fresh entry over it. Every response comes back exactly one cycle after acceptance.

Top module: `ecp_line_repair`

## Requirements
- R1: After reset no entry is valid, `full`, `rsp_valid` and `uncorrectable` are low, and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly the following cycle, and `req_ready` is low during that cycle. `req_op` is encoded as 00 read, 01 write and 10 allocate. The value 11 behaves as a read.
- R3: A read with no valid entries returns the raw line unchanged.
- R4: A read returns the raw line with bit `pos` of every valid entry replaced by that entry's substitute bit. All other bits are passed through unchanged.
- R5: An allocate with a free entry fills the lowest-index free entry with `req_pos` and `req_bit`. Its response is `req_line` corrected by the updated table.
- R6: When several valid entries name the same position, the highest-index one decides that bit on every later read.
- R7: A write stores `req_line[pos]` into the substitute bit of every valid entry. Its response equals `req_line`. A later read of a raw line that differs from the written data only at covered positions returns the written data.
- R8: `full` is high exactly when all N_ENT entries are valid. With the default N_ENT = 6, it rises on the response of the sixth successful allocate.
- R9: An allocate while `full` is high changes no entry. `uncorrectable` is high in that response cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 00 read, 01 write, 10 allocate, 11 read |
| req_line | input | LINE_W | Raw line (read), write data (write), or line to correct (allocate) |
| req_pos | input | PTR_W | Failed bit position for allocate |
| req_bit | input | 1 | True value of the failed position for allocate |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_line | output | LINE_W | Request line corrected by the updated entry table |
| full | output | 1 | All correction entries in use |
| uncorrectable | output | 1 | Allocate refused because the table was full |

## Verification
Reads are tried with an all-zero line, an all-one line and a mixed word pattern. Zero and one lines show whether a substitute bit forces its position in both directions rather than only setting or clearing it. The mixed pattern shows that uncovered bits pass through untouched. Repeated allocation of one position, with opposite values, separates highest-index precedence from first-match precedence. A write followed by a read of deliberately corrupted covered bits shows that substitute cells track the written data. An allocate after the table fills shows refusal, the single-cycle flag, and an unchanged table.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_ALLOC = 2'b10,
      OP_RSVD  = 2'b11
   } ecp_op_e;
endpackage

// File: rtl/ecp_entry_table.sv
module ecp_entry_table
   import ecp_pkg::*;
#(
   parameter int LINE_W = 512,
   parameter int N_ENT  = 6,
   localparam int PTR_W = $clog2(LINE_W),
   localparam int CNT_W = $clog2(N_ENT + 1)
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         acc,
   input  ecp_op_e                      op,
   input  logic [PTR_W-1:0]             pos_in,
   input  logic                         bit_in,
   input  logic [LINE_W-1:0]            wdata,
   output logic [N_ENT-1:0]             valid_n,
   output logic [N_ENT-1:0][PTR_W-1:0]  pos_n,
   output logic [N_ENT-1:0]             rbit_n,
   output logic                         full,
   output logic                         reject
);
   logic [N_ENT-1:0]            valid_q;
   logic [N_ENT-1:0][PTR_W-1:0] pos_q;
   logic [N_ENT-1:0]            rbit_q;
   logic [CNT_W-1:0]            cnt_q;
   logic                        do_alloc;
   logic                        do_write;

   assign full     = (cnt_q == CNT_W'(N_ENT));
   assign do_alloc = acc && (op == OP_ALLOC) && !full;
   assign reject   = acc && (op == OP_ALLOC) && full;
   assign do_write = acc && (op == OP_WRITE);

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      logic             e_v;
      logic [PTR_W-1:0] e_p;
      logic             e_b;
      always_comb begin
         e_v = valid_q[i];
         e_p = pos_q[i];
         e_b = rbit_q[i];
         if (do_alloc && (cnt_q == CNT_W'(i))) begin
            e_v = 1'b1;
            e_p = pos_in;
            e_b = bit_in;
         end else if (do_write && valid_q[i]) begin
            e_b = wdata[pos_q[i]];
         end
      end
      assign valid_n[i] = e_v;
      assign pos_n[i]   = e_p;
      assign rbit_n[i]  = e_b;

      // R8: an entry once taken is never released
      a_r8_entry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q[i] |=> valid_q[i]);
      // R6: a taken entry keeps the position it names
      a_r6_pos_kept: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q[i] |=> $stable(pos_q[i]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         pos_q   <= '0;
         rbit_q  <= '0;
         cnt_q   <= '0;
      end else begin
         valid_q <= valid_n;
         pos_q   <= pos_n;
         rbit_q  <= rbit_n;
         cnt_q   <= cnt_q + CNT_W'(do_alloc);
      end
   end

   // R8: full means every entry is in use
   a_r8_full_all_valid: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (&valid_q));
   // R9: a refused allocate leaves the table as it was
   a_r9_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> ($stable(valid_q) && $stable(pos_q) && $stable(rbit_q)));
endmodule

// File: rtl/ecp_line_patch.sv
module ecp_line_patch #(
   parameter int LINE_W = 512,
   parameter int N_ENT  = 6,
   localparam int PTR_W = $clog2(LINE_W)
)(
   input  logic [LINE_W-1:0]            raw,
   input  logic [N_ENT-1:0]             valid,
   input  logic [N_ENT-1:0][PTR_W-1:0]  pos,
   input  logic [N_ENT-1:0]             rbit,
   output logic [LINE_W-1:0]            fixed
);
   // Ascending order: a higher index overwrites a lower one.
   always_comb begin
      fixed = raw;
      for (int i = 0; i < N_ENT; i++) begin
         if (valid[i]) fixed[pos[i]] = rbit[i];
      end
   end
endmodule

// File: rtl/ecp_line_repair.sv
module ecp_line_repair
   import ecp_pkg::*;
#(
   parameter int LINE_W = 512,
   parameter int N_ENT  = 6,
   localparam int PTR_W = $clog2(LINE_W)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [LINE_W-1:0] req_line,
   input  logic [PTR_W-1:0]  req_pos,
   input  logic              req_bit,
   output logic              rsp_valid,
   output logic [LINE_W-1:0] rsp_line,
   output logic              full,
   output logic              uncorrectable
);
   if ((1 << PTR_W) != LINE_W) begin : g_bad_width
      $error("LINE_W must be a power of two");
   end
   if (N_ENT < 1 || N_ENT > 64) begin : g_bad_depth
      $error("N_ENT must lie in 1..64");
   end

   logic                        accept;
   logic [N_ENT-1:0]            valid_n;
   logic [N_ENT-1:0][PTR_W-1:0] pos_n;
   logic [N_ENT-1:0]            rbit_n;
   logic                        reject;
   logic [LINE_W-1:0]           fixed;
   logic                        rsp_valid_q;
   logic                        uncorr_q;
   logic [LINE_W-1:0]           line_q;

   assign req_ready = !rsp_valid_q;
   assign accept    = req_valid && req_ready;

   ecp_entry_table #(.LINE_W(LINE_W), .N_ENT(N_ENT)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (accept),
      .op      (ecp_op_e'(req_op)),
      .pos_in  (req_pos),
      .bit_in  (req_bit),
      .wdata   (req_line),
      .valid_n (valid_n),
      .pos_n   (pos_n),
      .rbit_n  (rbit_n),
      .full    (full),
      .reject  (reject)
   );

   ecp_line_patch #(.LINE_W(LINE_W), .N_ENT(N_ENT)) u_patch (
      .raw   (req_line),
      .valid (valid_n),
      .pos   (pos_n),
      .rbit  (rbit_n),
      .fixed (fixed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         uncorr_q    <= 1'b0;
         line_q      <= '0;
      end else begin
         rsp_valid_q <= accept;
         uncorr_q    <= reject;
         if (accept) line_q <= fixed;
      end
   end

   assign rsp_valid     = rsp_valid_q;
   assign rsp_line      = line_q;
   assign uncorrectable = uncorr_q;

   // R2: an accepted request is answered on the next cycle
   a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);
   // R2: a response lasts a single cycle
   a_r2_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R9: the refusal flag comes with a response while the table is full
   a_r9_uncorr_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      uncorrectable |-> (rsp_valid && full));
   // R9: the refusal flag is a one-cycle pulse
   a_r9_uncorr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      uncorrectable |=> !uncorrectable);
endmodule

// File: tb/ecp_line_repair_test.sv
module ecp_line_repair_test;
   localparam int LW = 512;
   localparam int NE = 6;
   localparam int PW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = 2'b00;
   logic [LW-1:0] req_line = '0;
   logic [PW-1:0] req_pos = '0;
   logic          req_bit = 1'b0;
   logic          rsp_valid;
   logic [LW-1:0] rsp_line;
   logic          full;
   logic          uncorrectable;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Bench-side record of the entries, built from R5..R7
   logic [PW-1:0] m_pos [NE];
   logic          m_bit [NE];
   int            m_cnt = 0;

   always #10 clk = ~clk;

   ecp_line_repair #(.LINE_W(LW), .N_ENT(NE)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_line(req_line), .req_pos(req_pos), .req_bit(req_bit),
      .rsp_valid(rsp_valid), .rsp_line(rsp_line), .full(full),
      .uncorrectable(uncorrectable)
   );

   function automatic logic [LW-1:0] model(input logic [LW-1:0] raw);
      logic [LW-1:0] r = raw;
      for (int i = 0; i < m_cnt; i++) r[m_pos[i]] = m_bit[i];
      return r;
   endfunction

   task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One request; leaves the bench at the negedge of the response cycle.
   task automatic issue(input logic [1:0] op, input logic [LW-1:0] line,
                        input logic [PW-1:0] pos, input logic b);
      @(negedge clk);
      chk("R2 ready before request", LW'(req_ready), LW'(1));
      req_valid = 1'b1; req_op = op; req_line = line; req_pos = pos; req_bit = b;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 rsp_valid one cycle later", LW'(rsp_valid), LW'(1));
      chk("R2 ready low during response", LW'(req_ready), LW'(0));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 full", LW'(full), LW'(0));
      chk("R1 rsp_valid", LW'(rsp_valid), LW'(0));
      chk("R1 uncorrectable", LW'(uncorrectable), LW'(0));
      chk("R1 ready", LW'(req_ready), LW'(1));
   endtask

   task automatic t_clean_read;
      logic [LW-1:0] p = {16{32'hA5C3_0F96}};
      issue(2'b00, p, '0, 1'b0);
      chk("R3 clean read mixed", rsp_line, p);
      issue(2'b11, '1, '0, 1'b0);
      chk("R2 op 11 reads", rsp_line, '1);
      @(negedge clk);
      chk("R2 response lasts one cycle", LW'(rsp_valid), LW'(0));
   endtask

   task automatic t_alloc;
      logic [LW-1:0] e;
      e = '0; e[5] = 1'b1;
      issue(2'b10, '0, 9'd5, 1'b1);
      m_pos[m_cnt] = 9'd5; m_bit[m_cnt] = 1'b1; m_cnt++;
      chk("R5 allocate response", rsp_line, e);
      issue(2'b10, '1, 9'd511, 1'b0);
      m_pos[m_cnt] = 9'd511; m_bit[m_cnt] = 1'b0; m_cnt++;
      e = '1; e[511] = 1'b0;
      chk("R5 second allocate response", rsp_line, e);
      issue(2'b00, '0, '0, 1'b0);
      chk("R4 read zeros", rsp_line, model('0));
      issue(2'b00, '1, '0, 1'b0);
      chk("R4 read ones", rsp_line, model('1));
      issue(2'b00, {16{32'hA5C3_0F96}}, '0, 1'b0);
      chk("R4 read mixed", rsp_line, model({16{32'hA5C3_0F96}}));
   endtask

   task automatic t_override;
      logic [LW-1:0] e;
      issue(2'b10, '0, 9'd5, 1'b0);
      m_pos[m_cnt] = 9'd5; m_bit[m_cnt] = 1'b0; m_cnt++;
      issue(2'b00, '0, '0, 1'b0);
      e = '0;
      chk("R6 later entry wins", rsp_line, e);
      chk("R6 model agrees", rsp_line, model('0));
   endtask

   task automatic t_write;
      logic [LW-1:0] w = {16{32'h1357_9BDF}};
      logic [LW-1:0] raw;
      w[5] = 1'b1; w[511] = 1'b1;
      issue(2'b01, w, '0, 1'b0);
      chk("R7 write response", rsp_line, w);
      for (int i = 0; i < m_cnt; i++) m_bit[i] = w[m_pos[i]];
      raw = w; raw[5] = 1'b0; raw[511] = 1'b0;
      issue(2'b00, raw, '0, 1'b0);
      chk("R7 read of stuck cells", rsp_line, w);
   endtask

   task automatic t_fill;
      int ps [3] = '{100, 200, 300};
      for (int k = 0; k < 3; k++) begin
         issue(2'b10, '0, PW'(ps[k]), 1'b1);
         m_pos[m_cnt] = PW'(ps[k]); m_bit[m_cnt] = 1'b1; m_cnt++;
         chk("R8 full only at last entry", LW'(full), LW'(m_cnt == NE));
         chk("R5 ascending fill response", rsp_line, model('0));
      end
   endtask

   task automatic t_reject;
      issue(2'b10, '0, 9'd7, 1'b1);
      chk("R9 uncorrectable raised", LW'(uncorrectable), LW'(1));
      chk("R9 refused response", rsp_line, model('0));
      @(negedge clk);
      chk("R9 uncorrectable one cycle", LW'(uncorrectable), LW'(0));
      issue(2'b00, '0, '0, 1'b0);
      chk("R9 table unchanged", rsp_line, model('0));
      chk("R8 full stays", LW'(full), LW'(1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_clean_read();
      t_alloc();
      t_override();
      t_write();
      t_fill();
      t_reject();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule